// File: doc/BRIEF.md
# Replicated Shared Memory Node Controller

This block is the memory-side controller of one node on a ring that keeps a copy of the same shared memory in every node. The local host reads and writes words through a host port. Every write the host makes is stored in the local memory and also queued as a write message (source node, address, data) for the ring. Write messages that arrive from the ring are stored in the local memory without the host seeing them. After the local write they are passed on unchanged, so they continue around the ring. A message whose source is this node has completed its trip. It is absorbed: it is not written and not passed on.

The host access and one incoming ring write can complete in the same clock cycle. The host side uses the memory's read/write port and the ring side uses a second write port. The amount of memory that is decoded is picked at run time from six window sizes, each a power-of-two step up from the smallest. A per-word enable map chooses which locations raise a host interrupt when the ring writes them. The interrupt stays latched and records the address of the first write that caused it.

The host request, ring receive and ring transmit interfaces are valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A transmit message is held stable while `tx_valid` is high and `tx_ready` is low. Back-pressure comes from the shared transmit queue. A host write waits for a free slot. A foreign ring message waits for a free slot. A host write offered in the same cycle as an accepted foreign message needs two free slots, so the ring traffic is never blocked behind the host. Host reads and this node's own returning messages are always accepted.

Top module: `rsm_node`

## Requirements
- R1: An accepted in-window host write stores its data at its address, readable from the next cycle on. It also enqueues a transmit message with source `node_id`, the host address and the host data.
- R2: An accepted receive message whose source differs from `node_id` and whose address is in the window stores its data locally. It is then enqueued unchanged (same source, address and data) for transmission.
- R3: A host access and a foreign receive write accepted in the same cycle both complete. If both write the same word, the word keeps the received data, and the host write is still transmitted. When both enqueue in one cycle, the host message leaves first.
- R4: A foreign in-window receive write to a word whose enable bit is 1 sets `irq`. If `irq` was low (or is being cleared in that cycle), `irq_addr` takes the write's address. `irq` stays high until a cycle with `irq_clr` high, and further events while `irq` is pending leave `irq_addr` unchanged. A write to a word whose enable bit is 0 raises nothing. The enable bit for word `ien_addr` is written with `ien_val` when `ien_we` is high. A receive write in the same cycle sees the old bit.
- R5: `cfg_size` codes 0,1,2,3,4,5 decode 2^(B), 2^(B+2), 2^(B+3), 2^(B+4), 2^(B+5), 2^(B+6) words, where B is the `BASE_LOG2` parameter; codes 6 and 7 act as 5. An address at or above the window size is out of window. Out-of-window host writes are accepted but neither stored nor transmitted. Out-of-window host reads return zero. Out-of-window receive writes are not stored and raise no interrupt, but are still forwarded.
- R6: A receive message whose source equals `node_id` is always accepted and dropped: no store, no forward, no interrupt.
- R7: With F free queue slots, `rx_ready` = own-source or F>=1. `hst_ready` is 1 for a read, and for a write it is F>=2 when a foreign receive message is accepted in that cycle, otherwise F>=1. A dequeue in the same cycle does not add to F.
- R8: `tx_valid` is high exactly while the queue is not empty. Messages leave in enqueue order, and the message is held stable while `tx_ready` is low.
- R9: An accepted host read gives `rsp_valid` high in the next cycle with the word as it was before any write of the accepting cycle.
- R10: After reset, `tx_valid`, `rsp_valid` and `irq` are low, every memory word and enable bit is zero, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | NODE_W | This node's ring identity |
| cfg_size | input | 3 | Decoded memory window code |
| hst_valid | input | 1 | Host request valid |
| hst_ready | output | 1 | Host request accepted |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Host word address |
| hst_wdata | input | DATA_W | Host write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| rx_valid | input | 1 | Ring message valid |
| rx_ready | output | 1 | Ring message accepted |
| rx_src | input | NODE_W | Originating node of the message |
| rx_addr | input | ADDR_W | Message word address |
| rx_data | input | DATA_W | Message data |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Ring takes the outgoing message |
| tx_src | output | NODE_W | Outgoing originating node |
| tx_addr | output | ADDR_W | Outgoing word address |
| tx_data | output | DATA_W | Outgoing data |
| ien_we | input | 1 | Write one interrupt-enable bit |
| ien_addr | input | ADDR_W | Word whose enable bit is written |
| ien_val | input | 1 | New enable bit value |
| irq_clr | input | 1 | Clear the pending interrupt |
| irq | output | 1 | Interrupt pending |
| irq_addr | output | ADDR_W | Address of the first interrupting write |

## Verification
The bench builds the block with `BASE_LOG2` = 2, `ADDR_W` = 10, `DATA_W` = 16, `NODE_W` = 4 and a four-entry transmit queue. That gives a 256-word memory whose windows range from 4 to 256 words. Every window size can then be reached, and addresses above the physical memory exist at all settings. The short queue fills within a few stalled cycles, which exercises the single-slot and two-slot back-pressure cases and the hold rule at the transmit port. A narrow random address range makes same-word collisions and repeated interrupt events frequent.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  // number of window steps above the smallest window
  localparam int unsigned WIN_STEPS = 6;

  // log2 growth of the decoded window for each size code
  function automatic int unsigned win_shift(input logic [2:0] code);
    case (code)
      3'd0:    win_shift = 0;
      3'd1:    win_shift = 2;
      3'd2:    win_shift = 3;
      3'd3:    win_shift = 4;
      3'd4:    win_shift = 5;
      default: win_shift = WIN_STEPS;
    endcase
  endfunction

endpackage

// File: rtl/rsm_addr_window.sv
module rsm_addr_window #(
  parameter int ADDR_W    = 16,
  parameter int BASE_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size_code,
  output logic              hit
);
  import rsm_pkg::*;

  int unsigned lim_log2;

  always_comb begin
    lim_log2 = BASE_LOG2 + win_shift(size_code);
    hit      = ((addr >> lim_log2) == '0);
  end

endmodule

// File: rtl/rsm_mem.sv
module rsm_mem #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [DATA_W-1:0] hw_data,
  input  logic              hr_en,
  input  logic [IDX_W-1:0]  hr_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              nw_en,
  input  logic [IDX_W-1:0]  nw_idx,
  input  logic [DATA_W-1:0] nw_data
);
  localparam int WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rd_q;

  // host port first, network port second: network wins a same-word clash
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else begin
      if (hw_en) mem_q[hw_idx] <= hw_data;
      if (nw_en) mem_q[nw_idx] <= nw_data;
    end
  end

  // read returns the word before this cycle's writes
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (hr_en) rd_q <= mem_q[hr_idx];
  end

  assign rd_data = rd_q;

  p_net_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && nw_en && (hw_idx == nw_idx)) |=> (mem_q[$past(nw_idx)] == $past(nw_data)));

endmodule

// File: rtl/rsm_txq.sv
module rsm_txq #(
  parameter int W     = 40,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push0,
  input  logic [W-1:0]               d0,
  input  logic                       push1,
  input  logic [W-1:0]               d1,
  output logic [$clog2(DEPTH+1)-1:0] free,
  input  logic                       pop,
  output logic                       out_valid,
  output logic [W-1:0]               out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q, wptr1;
  logic [CNT_W-1:0] cnt_q;

  // second push goes one slot behind the first when both fire
  assign wptr1 = wptr_q + PTR_W'(push0);

  always_ff @(posedge clk) begin
    if (push0) slot_q[wptr_q] <= d0;
    if (push1) slot_q[wptr1]  <= d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + PTR_W'(push0) + PTR_W'(push1);
      rptr_q <= rptr_q + PTR_W'(pop);
      cnt_q  <= cnt_q + CNT_W'(push0) + CNT_W'(push1) - CNT_W'(pop);
    end
  end

  assign free      = CNT_W'(DEPTH) - cnt_q;
  assign out_valid = (cnt_q != '0);
  assign out_data  = slot_q[rptr_q];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  p_push_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((CNT_W+1)'(push0) + (CNT_W+1)'(push1)) <= {1'b0, free});

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> out_valid);

endmodule

// File: rtl/rsm_irq.sv
module rsm_irq #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we,
  input  logic [IDX_W-1:0]  ien_idx,
  input  logic              ien_val,
  input  logic              ev_en,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              clr,
  output logic              irq,
  output logic [ADDR_W-1:0] irq_addr
);
  localparam int WORDS = 1 << IDX_W;

  logic [WORDS-1:0]  ien_q;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ev_hit;

  // enable lookup sees the bit before any same-cycle update
  assign ev_hit = ev_en && ien_q[ev_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q[ien_idx] <= ien_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= ev_hit | (pend_q & ~clr);
      if (ev_hit && (!pend_q || clr)) addr_q <= ev_addr;
    end
  end

  assign irq      = pend_q;
  assign irq_addr = addr_q;

  p_irq_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);

  p_irq_first_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> $stable(irq_addr));

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_en));

endmodule

// File: rtl/rsm_node.sv
module rsm_node #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NODE_W    = 6,
  parameter int BASE_LOG2 = 4,
  parameter int DEPTH     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] node_id,
  input  logic [2:0]        cfg_size,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_write,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [NODE_W-1:0] rx_src,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [NODE_W-1:0] tx_src,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [DATA_W-1:0] tx_data,
  input  logic              ien_we,
  input  logic [ADDR_W-1:0] ien_addr,
  input  logic              ien_val,
  input  logic              irq_clr,
  output logic              irq,
  output logic [ADDR_W-1:0] irq_addr
);
  localparam int IDX_W = BASE_LOG2 + rsm_pkg::WIN_STEPS;
  localparam int MSG_W = NODE_W + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic              host_hit, net_hit;
  logic              rx_own, rx_fire, rx_fwd;
  logic              h_fire, h_wr, h_rd;
  logic [CNT_W-1:0]  q_free;
  logic [CNT_W:0]    need;
  logic              q_valid;
  logic [MSG_W-1:0]  q_out;
  logic [DATA_W-1:0] mem_rd;
  logic              rsp_q, rhit_q;

  rsm_addr_window #(.ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)) u_win_host (
    .addr(hst_addr), .size_code(cfg_size), .hit(host_hit));

  rsm_addr_window #(.ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2)) u_win_net (
    .addr(rx_addr), .size_code(cfg_size), .hit(net_hit));

  // receive side: own returning messages are absorbed, foreign ones need a slot
  assign rx_own   = (rx_src == node_id);
  assign rx_ready = rx_own || (q_free != '0);
  assign rx_fire  = rx_valid && rx_ready;
  assign rx_fwd   = rx_fire && !rx_own;

  // host side: writes need a slot beyond the one a forward takes
  assign need      = rx_fwd ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
  assign hst_ready = !hst_write || ({1'b0, q_free} >= need);
  assign h_fire    = hst_valid && hst_ready;
  assign h_wr      = h_fire && hst_write && host_hit;
  assign h_rd      = h_fire && !hst_write;

  rsm_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .hw_en(h_wr), .hw_idx(hst_addr[IDX_W-1:0]), .hw_data(hst_wdata),
    .hr_en(h_rd), .hr_idx(hst_addr[IDX_W-1:0]), .rd_data(mem_rd),
    .nw_en(rx_fwd && net_hit), .nw_idx(rx_addr[IDX_W-1:0]), .nw_data(rx_data));

  rsm_txq #(.W(MSG_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push0(h_wr), .d0({node_id, hst_addr, hst_wdata}),
    .push1(rx_fwd), .d1({rx_src, rx_addr, rx_data}),
    .free(q_free), .pop(q_valid && tx_ready),
    .out_valid(q_valid), .out_data(q_out));

  assign tx_valid = q_valid;
  assign {tx_src, tx_addr, tx_data} = q_out;

  rsm_irq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ien_we(ien_we), .ien_idx(ien_addr[IDX_W-1:0]), .ien_val(ien_val),
    .ev_en(rx_fwd && net_hit), .ev_idx(rx_addr[IDX_W-1:0]), .ev_addr(rx_addr),
    .clr(irq_clr), .irq(irq), .irq_addr(irq_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q  <= 1'b0;
      rhit_q <= 1'b0;
    end else begin
      rsp_q  <= h_rd;
      rhit_q <= host_hit;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_rdata = rhit_q ? mem_rd : '0;

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_src) && $stable(tx_addr) && $stable(tx_data)));

  p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && !hst_write) |=> rsp_valid);

  p_own_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_own && !hst_valid && !tx_valid) |=> !tx_valid);

endmodule

// File: tb/rsm_node_tb.sv
`timescale 1ns/1ps
module rsm_node_tb;
  localparam int AW = 10, DW = 16, NW = 4, BL = 2, DEP = 4;
  localparam int IDX = BL + 6;
  localparam int WORDS = 1 << IDX;
  localparam logic [NW-1:0] ME = 4'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] d_sz = 3'd5;
  logic d_hv = 0, d_hw = 0, d_rv = 0, d_tr = 1, d_iwe = 0, d_iv = 0, d_clr = 0;
  logic [AW-1:0] d_ha = 0, d_ra = 0, d_ia = 0;
  logic [DW-1:0] d_hd = 0, d_rd = 0;
  logic [NW-1:0] d_rs = 0;

  logic hst_ready, rsp_valid, rx_ready, tx_valid, irq;
  logic [DW-1:0] rsp_rdata, tx_data;
  logic [NW-1:0] tx_src;
  logic [AW-1:0] tx_addr, irq_addr;

  rsm_node #(.ADDR_W(AW), .DATA_W(DW), .NODE_W(NW), .BASE_LOG2(BL), .DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(ME), .cfg_size(d_sz),
    .hst_valid(d_hv), .hst_ready(hst_ready), .hst_write(d_hw), .hst_addr(d_ha),
    .hst_wdata(d_hd), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rx_valid(d_rv), .rx_ready(rx_ready), .rx_src(d_rs), .rx_addr(d_ra), .rx_data(d_rd),
    .tx_valid(tx_valid), .tx_ready(d_tr), .tx_src(tx_src), .tx_addr(tx_addr), .tx_data(tx_data),
    .ien_we(d_iwe), .ien_addr(d_ia), .ien_val(d_iv), .irq_clr(d_clr),
    .irq(irq), .irq_addr(irq_addr));

  // stimulus for the next step
  logic [2:0] g_sz = 3'd5;
  logic g_hv = 0, g_hw = 0, g_rv = 0, g_tr = 1, g_iwe = 0, g_iv = 0, g_clr = 0;
  logic [AW-1:0] g_ha = 0, g_ra = 0, g_ia = 0;
  logic [DW-1:0] g_hd = 0, g_rd = 0;
  logic [NW-1:0] g_rs = 0;

  // reference model
  logic [DW-1:0] m_mem [WORDS];
  bit            m_ien [WORDS];
  logic [NW-1:0] q_s [16];
  logic [AW-1:0] q_a [16];
  logic [DW-1:0] q_d [16];
  int q_h = 0, q_n = 0;
  bit m_irq = 0;
  logic [AW-1:0] m_iaddr = 0;
  bit rd_pend = 0;
  logic [DW-1:0] rd_exp = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  string ctag = "";

  function automatic string tagor(string def);
    return (ctag != "") ? ctag : def;
  endfunction

  function automatic bit in_win(logic [AW-1:0] a, logic [2:0] sz);
    int sh;
    case (sz)
      3'd0: sh = 0; 3'd1: sh = 2; 3'd2: sh = 3; 3'd3: sh = 4; 3'd4: sh = 5;
      default: sh = 6;
    endcase
    return int'(a) < (1 << (BL + sh));
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qpush(logic [NW-1:0] s, logic [AW-1:0] a, logic [DW-1:0] d);
    int t = (q_h + q_n) % 16;
    q_s[t] = s; q_a[t] = a; q_d[t] = d;
    q_n++;
  endtask

  task automatic idle();
    g_hv = 0; g_rv = 0; g_iwe = 0; g_clr = 0;
  endtask

  task automatic step();
    bit own, fwd, exp_rr, exp_hr, hfire, ev, hhit, rhit;
    int fr;
    @(negedge clk);
    // outputs reflect the state after the last edge
    chk(rsp_valid == rd_pend, tagor("R9"), rsp_valid, rd_pend);
    if (rd_pend) chk(rsp_rdata == rd_exp, tagor("R9"), rsp_rdata, rd_exp);
    chk(irq == m_irq, tagor("R4"), irq, m_irq);
    if (m_irq) chk(irq_addr == m_iaddr, tagor("R4"), irq_addr, m_iaddr);
    chk(tx_valid == (q_n != 0), tagor("R8"), tx_valid, q_n != 0);
    if (tx_valid && q_n != 0)
      chk({tx_src, tx_addr, tx_data} == {q_s[q_h], q_a[q_h], q_d[q_h]},
          tagor(q_s[q_h] == ME ? "R1" : "R2"),
          {tx_src, tx_addr, tx_data}, {q_s[q_h], q_a[q_h], q_d[q_h]});
    // drive
    d_sz = g_sz; d_hv = g_hv; d_hw = g_hw; d_ha = g_ha; d_hd = g_hd;
    d_rv = g_rv; d_rs = g_rs; d_ra = g_ra; d_rd = g_rd; d_tr = g_tr;
    d_iwe = g_iwe; d_ia = g_ia; d_iv = g_iv; d_clr = g_clr;
    #1;
    fr = DEP - q_n;
    own = (g_rs == ME);
    exp_rr = own || (fr >= 1);
    fwd = g_rv && exp_rr && !own;
    exp_hr = !g_hw || (fr >= (fwd ? 2 : 1));
    chk(rx_ready == exp_rr, tagor("R7"), rx_ready, exp_rr);
    chk(hst_ready == exp_hr, tagor("R7"), hst_ready, exp_hr);
    // model update for the coming edge
    hfire = g_hv && exp_hr;
    hhit = in_win(g_ha, g_sz);
    rhit = in_win(g_ra, g_sz);
    rd_pend = hfire && !g_hw;
    if (rd_pend) rd_exp = hhit ? m_mem[g_ha[IDX-1:0]] : '0;
    if (q_n != 0 && g_tr) begin q_h = (q_h + 1) % 16; q_n--; end
    if (hfire && g_hw && hhit) begin
      m_mem[g_ha[IDX-1:0]] = g_hd;
      qpush(ME, g_ha, g_hd);
    end
    ev = 0;
    if (fwd) begin
      if (rhit) begin
        ev = m_ien[g_ra[IDX-1:0]];
        m_mem[g_ra[IDX-1:0]] = g_rd;
      end
      qpush(g_rs, g_ra, g_rd);
    end
    if (ev && (!m_irq || g_clr)) m_iaddr = g_ra;
    m_irq = ev || (m_irq && !g_clr);
    if (g_iwe) m_ien[g_ia[IDX-1:0]] = g_iv;
  endtask

  task automatic hwr(int a, int d);
    idle(); g_hv = 1; g_hw = 1; g_ha = AW'(a); g_hd = DW'(d); step();
  endtask
  task automatic hrd(int a);
    idle(); g_hv = 1; g_hw = 0; g_ha = AW'(a); step();
  endtask
  task automatic rxw(int s, int a, int d);
    idle(); g_rv = 1; g_rs = NW'(s); g_ra = AW'(a); g_rd = DW'(d); step();
  endtask
  task automatic ien(int a, bit v);
    idle(); g_iwe = 1; g_ia = AW'(a); g_iv = v; step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) begin m_mem[i] = '0; m_ien[i] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(tx_valid == 0, "R10", tx_valid, 0);
    chk(rsp_valid == 0, "R10", rsp_valid, 0);
    chk(irq == 0, "R10", irq, 0);
    rst_n = 1;
    ctag = "R10"; hrd(200); idle(); step();

    ctag = "R1"; hwr(3, 16'hA5A5); idle(); step(); hrd(3); idle(); step();
    ctag = "R9"; hrd(3); hwr(3, 16'h0F0F); hrd(3); idle(); step();

    ctag = "R2"; rxw(2, 7, 16'h1234); idle(); step(); hrd(7); idle(); step();

    // R3: same-word collision, and read alongside a network write
    ctag = "R3";
    idle(); g_hv = 1; g_hw = 1; g_ha = 9; g_hd = 16'h1111;
    g_rv = 1; g_rs = 2; g_ra = 9; g_rd = 16'h2222; step();
    idle(); g_hv = 1; g_hw = 0; g_ha = 9; g_rv = 1; g_rs = 3; g_ra = 9; g_rd = 16'h3333; step();
    idle(); step(); hrd(9); idle(); step(); step();

    // R4: interrupt latch, first address, clear
    ctag = "R4";
    ien(11, 1); ien(12, 1);
    rxw(3, 13, 16'h7); rxw(3, 11, 16'h8); rxw(3, 12, 16'h9); idle(); step();
    idle(); g_clr = 1; step(); idle(); step();
    idle(); g_clr = 1; g_rv = 1; g_rs = 1; g_ra = 12; g_rd = 16'hA; step();
    idle(); g_clr = 1; step();
    idle(); g_iwe = 1; g_ia = 11; g_iv = 0; g_rv = 1; g_rs = 1; g_ra = 11; g_rd = 1; step();
    idle(); g_clr = 1; step(); rxw(1, 11, 2); idle(); step();

    // R5: window sizes
    ctag = "R5";
    g_sz = 3'd0; ien(50, 1);
    hwr(40, 16'hBEEF); hrd(40); rxw(2, 50, 16'hCAFE); idle(); step(); step();
    hwr(3, 16'h4444); hrd(3); idle(); step();
    g_sz = 3'd7; hwr(255, 16'h5555); hrd(255); hwr(300, 1); hrd(300); idle(); step();
    g_sz = 3'd5;

    ctag = "R6"; rxw(ME, 5, 16'hDEAD); idle(); step(); hrd(5); idle(); step();
    ien(5, 1); rxw(ME, 5, 1); idle(); step();

    // R7/R8: fill the queue with the ring stalled, then drain
    ctag = "R7"; g_tr = 0;
    for (int k = 0; k < 3; k++) hwr(20 + k, k);
    idle(); g_hv = 1; g_hw = 1; g_ha = 30; g_hd = 1; g_rv = 1; g_rs = 2; g_ra = 31; g_rd = 2; step();
    hwr(23, 9); rxw(2, 24, 9); rxw(ME, 25, 9); hrd(20);
    ctag = "R8"; idle(); step(); step();
    g_tr = 1; for (int k = 0; k < 6; k++) step();

    // constrained random traffic
    ctag = "";
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) g_sz = 3'($urandom % 8);
      g_hv = ($urandom % 3) != 0;
      g_hw = $urandom % 2;
      g_ha = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 24);
      g_hd = DW'($urandom);
      g_rv = ($urandom % 3) != 0;
      g_rs = ($urandom % 4 == 0) ? ME : NW'($urandom);
      g_ra = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 24);
      g_rd = DW'($urandom);
      g_tr = ($urandom % 4) != 0;
      g_clr = ($urandom % 16) == 0;
      g_iwe = ($urandom % 4) == 0;
      g_ia = AW'($urandom % 24);
      g_iv = $urandom % 2;
      step();
    end
    idle(); g_tr = 1;
    for (int k = 0; k < 8; k++) step();

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule